// File: doc/BRIEF.md
# Parity-Checked Word Serializer

This block turns a stream of parallel words into one serial bit stream running on a fast bit clock. A free-running divide counter splits the bit clock into word slots of `WORD_W` bit times. At the end of each slot the block captures the parallel word and its parity bit. It raises or lowers a validity flag for that word and shifts the word out most significant bit first, with no idle bit between words.

Several controls shape the outputs. The main serial output can be inverted through an active-low control. A second serial output, for loopback use, carries the same uninverted stream and has its own active-low enable. A gated copy of the bit clock goes out through an active-high enable. A word-rate clock goes back to the upstream data source, and its rising edge can be placed at one of four offsets from the load instant. That source can then launch data on a phase that suits its board timing.

Control is a two-state machine. `ST_FILL` is entered on reset. It holds the shift path at zero until the first word slot completes. The transition `FILL_TO_STREAM` fires on the first load. `ST_STREAM` then loads a word on every slot boundary and shifts on every other bit time. It stays in that state until reset (transition `STREAM_HOLD`), and reset returns the machine to `ST_FILL` from either state.

Top module: `pser_tx`

## Requirements
- R1: Exactly one word is loaded every 16 bit-clock cycles. After a reset cycle, the first load happens on the 16th rising edge with reset low.
- R2: The loaded word leaves on the serial stream with bit 15 first, in the bit time right after the load edge, and bit 0 last. The next word's bit 15 follows bit 0 with no gap.
- R3: `valid_out` updates only at a load edge and then holds for the whole word. It is 1 when `parity_in` equals the XOR of the 16 captured bits, so parity is 0 for an even count of ones and 1 for an odd count. It is 0 otherwise.
- R4: `word_in` and `parity_in` have no effect on any output except in the cycle that ends at a load edge.
- R5: `inv_n` = 0 inverts every bit on `ser_out`. `inv_n` = 1 passes the stream unchanged. The control acts combinationally on the current bit.
- R6: With `lpbk_en_n` = 0, `lpbk_out` carries the serial stream before inversion. With `lpbk_en_n` = 1, `lpbk_out` is constant 0.
- R7: With `sclk_en` = 1, `sclk_out` follows `clk_ser`. With `sclk_en` = 0, `sclk_out` is constant 0.
- R8: `wclk_out` is high for 8 bit times out of 16. Its rising edge comes 4×`phase_sel` bit-clock edges after the load edge (`phase_sel` 0..3 gives 0, 4, 8 or 12).
- R9: Reset is synchronous and active high. It clears the divide counter, the shift path and `valid_out`.
- R10: In `ST_FILL` the uninverted serial stream is 0. The machine enters `ST_STREAM` on the first load and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 16 | Parallel data word, bit 15 is the MSB |
| parity_in | input | 1 | Parity bit supplied with the word (XOR of its bits) |
| inv_n | input | 1 | Active-low inversion of `ser_out` |
| lpbk_en_n | input | 1 | Active-low enable of `lpbk_out` |
| sclk_en | input | 1 | Active-high enable of `sclk_out` |
| phase_sel | input | 2 | Word-clock phase: rising edge 4×value bit times after load |
| ser_out | output | 1 | Main serial data |
| lpbk_out | output | 1 | Loopback serial data, uninverted |
| sclk_out | output | 1 | Gated bit clock |
| wclk_out | output | 1 | Word-rate clock for the upstream source |
| valid_out | output | 1 | Parity agreement flag for the word being sent |

## Verification
Two events can coincide on a load edge: the capture of a new word with its parity verdict, and the last bit of the previous word leaving the shifter. The bench provokes this edge with words that change every cycle, mixed good and bad parity, and inversion and phase changes applied right before the boundary. On the cycle after the edge, a queue-based model checks that `valid_out` belongs to the new word and that the new word's MSB, not a stale bit, sits on both serial outputs. A second overlap is a mid-word reset against a pending load; the model checks that the next load lands 16 edges after the reset.

// File: rtl/pser_pkg.sv
package pser_pkg;

    typedef enum logic [0:0] {
        ST_FILL   = 1'b0,
        ST_STREAM = 1'b1
    } pser_state_t;

endpackage

// File: rtl/pser_divider.sv
module pser_divider #(
    parameter int WORD_W = 16,
    parameter int PHASES = 4,
    localparam int CW    = $clog2(WORD_W),
    localparam int PW    = $clog2(PHASES),
    localparam int STEP  = WORD_W / PHASES,
    localparam int HALF  = WORD_W / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase_sel,
    output logic          load,
    output logic          wclk
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] offs;
    logic          wclk_q;

    // Level of the word clock for a given slot position and offset.
    function automatic logic slot_level(input logic [CW-1:0] pos,
                                        input logic [CW-1:0] off);
        logic [CW-1:0] rel;
        rel = pos - off;
        return rel < CW'(HALF);
    endfunction

    assign cnt_nxt = cnt_q + CW'(1);
    assign load    = (cnt_q == CW'(WORD_W - 1));
    assign offs    = CW'(phase_sel) * CW'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wclk_q <= slot_level('0, offs);
        end else begin
            cnt_q  <= cnt_nxt;
            wclk_q <= slot_level(cnt_nxt, offs);
        end
    end

    assign wclk = wclk_q;

endmodule

// File: rtl/pser_capture.sv
module pser_capture #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              parity_in,
    output logic              valid
);

    logic [WORD_W:0] acc;
    logic            match;
    logic            valid_q;

    assign acc[0] = 1'b0;

    // Running XOR chain across the word.
    for (genvar g = 0; g < WORD_W; g++) begin : g_par
        assign acc[g+1] = acc[g] ^ word_in[g];
    end

    assign match = (acc[WORD_W] == parity_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= match;
        end
    end

    assign valid = valid_q;

endmodule

// File: rtl/pser_shifter.sv
module pser_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              msb
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= word_in;
        end else if (shift_en) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/pser_outstage.sv
module pser_outstage (
    input  logic clk,
    input  logic raw_bit,
    input  logic inv_n,
    input  logic lpbk_en_n,
    input  logic sclk_en,
    output logic ser_out,
    output logic lpbk_out,
    output logic sclk_out
);

    always_comb begin
        ser_out  = inv_n ? raw_bit : ~raw_bit;
        lpbk_out = lpbk_en_n ? 1'b0 : raw_bit;
        sclk_out = sclk_en & clk;
    end

endmodule

// File: rtl/pser_tx.sv
module pser_tx #(
    parameter int WORD_W = 16,
    parameter int PHASES = 4,
    localparam int PW    = $clog2(PHASES)
) (
    input  logic              clk_ser,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              parity_in,
    input  logic              inv_n,
    input  logic              lpbk_en_n,
    input  logic              sclk_en,
    input  logic [PW-1:0]     phase_sel,
    output logic              ser_out,
    output logic              lpbk_out,
    output logic              sclk_out,
    output logic              wclk_out,
    output logic              valid_out
);

    import pser_pkg::*;

    pser_state_t state_q;
    pser_state_t state_nxt;
    logic        load;
    logic        shift_en;
    logic        raw_bit;

    // State register.
    always_ff @(posedge clk_ser) begin
        if (rst) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state decode.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_FILL:   state_nxt = load ? ST_STREAM : ST_FILL;
            ST_STREAM: state_nxt = ST_STREAM;
            default:   state_nxt = ST_FILL;
        endcase
    end

    // Per-state controls.
    always_comb begin
        shift_en = 1'b0;
        unique case (state_q)
            ST_FILL:   shift_en = 1'b0;
            ST_STREAM: shift_en = ~load;
            default:   shift_en = 1'b0;
        endcase
    end

    pser_divider #(
        .WORD_W (WORD_W),
        .PHASES (PHASES)
    ) u_div (
        .clk       (clk_ser),
        .rst       (rst),
        .phase_sel (phase_sel),
        .load      (load),
        .wclk      (wclk_out)
    );

    pser_capture #(
        .WORD_W (WORD_W)
    ) u_cap (
        .clk       (clk_ser),
        .rst       (rst),
        .load      (load),
        .word_in   (word_in),
        .parity_in (parity_in),
        .valid     (valid_out)
    );

    pser_shifter #(
        .WORD_W (WORD_W)
    ) u_shf (
        .clk      (clk_ser),
        .rst      (rst),
        .load     (load),
        .shift_en (shift_en),
        .word_in  (word_in),
        .msb      (raw_bit)
    );

    pser_outstage u_out (
        .clk       (clk_ser),
        .raw_bit   (raw_bit),
        .inv_n     (inv_n),
        .lpbk_en_n (lpbk_en_n),
        .sclk_en   (sclk_en),
        .ser_out   (ser_out),
        .lpbk_out  (lpbk_out),
        .sclk_out  (sclk_out)
    );

endmodule

// File: rtl/pser_checker.sv
module pser_checker #(
    parameter int WORD_W = 16,
    parameter int PHASES = 4,
    localparam int CW    = $clog2(WORD_W),
    localparam int PW    = $clog2(PHASES),
    localparam int STEP  = WORD_W / PHASES
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  load,
    input logic                  raw_bit,
    input pser_pkg::pser_state_t state_q,
    input logic [WORD_W-1:0]     word_in,
    input logic                  parity_in,
    input logic                  inv_n,
    input logic                  lpbk_en_n,
    input logic [PW-1:0]         phase_sel,
    input logic                  ser_out,
    input logic                  lpbk_out,
    input logic                  wclk_out,
    input logic                  valid_out
);

    logic [CW-1:0] slot;
    logic [1:0]    age;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            age  <= '0;
        end else begin
            slot <= load ? '0 : slot + CW'(1);
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    assert_load_period_R1: assert property (@(posedge clk) disable iff (rst)
        load |-> (slot == CW'(WORD_W - 1)));

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (raw_bit == $past(word_in[WORD_W-1])));

    assert_valid_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(valid_out));

    assert_valid_value_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (valid_out == ((^$past(word_in)) == $past(parity_in))));

    assert_invert_R5: assert property (@(posedge clk) disable iff (rst)
        ser_out == (inv_n ? raw_bit : !raw_bit));

    assert_lpbk_off_R6: assert property (@(posedge clk) disable iff (rst)
        lpbk_en_n |-> !lpbk_out);

    assert_lpbk_on_R6: assert property (@(posedge clk) disable iff (rst)
        !lpbk_en_n |-> (lpbk_out == raw_bit));

    assert_wclk_rise_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(wclk_out) && age == 2'd3 && $past(phase_sel) == phase_sel
         && $past(phase_sel, 2) == phase_sel)
        |-> (slot == CW'(phase_sel) * CW'(STEP)));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!valid_out && !raw_bit));

    assert_fill_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == pser_pkg::ST_FILL) |-> !raw_bit);

endmodule

bind pser_tx pser_checker #(
    .WORD_W (WORD_W),
    .PHASES (PHASES)
) u_pser_chk (
    .clk       (clk_ser),
    .rst       (rst),
    .load      (load),
    .raw_bit   (raw_bit),
    .state_q   (state_q),
    .word_in   (word_in),
    .parity_in (parity_in),
    .inv_n     (inv_n),
    .lpbk_en_n (lpbk_en_n),
    .phase_sel (phase_sel),
    .ser_out   (ser_out),
    .lpbk_out  (lpbk_out),
    .wclk_out  (wclk_out),
    .valid_out (valid_out)
);

// File: tb/pser_tx_bench.sv
module pser_tx_bench;

    logic        clk_ser = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] word_in = '0;
    logic        parity_in = 1'b0;
    logic        inv_n = 1'b1;
    logic        lpbk_en_n = 1'b1;
    logic        sclk_en = 1'b1;
    logic [1:0]  phase_sel = 2'd0;
    logic        ser_out, lpbk_out, sclk_out, wclk_out, valid_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Behavioural reference state.
    int   m_cnt = 0;
    bit   m_q[$];
    logic m_raw = 1'b0;
    logic m_valid = 1'b0;
    logic m_wclk = 1'b1;

    always #5 clk_ser = ~clk_ser;

    pser_tx u_pser_tx (
        .clk_ser   (clk_ser),
        .rst       (rst),
        .word_in   (word_in),
        .parity_in (parity_in),
        .inv_n     (inv_n),
        .lpbk_en_n (lpbk_en_n),
        .sclk_en   (sclk_en),
        .phase_sel (phase_sel),
        .ser_out   (ser_out),
        .lpbk_out  (lpbk_out),
        .sclk_out  (sclk_out),
        .wclk_out  (wclk_out),
        .valid_out (valid_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    function automatic logic wlevel(input int c, input int p);
        return ((c - 4 * p + 16) % 16) < 8;
    endfunction

    // Reference update at every edge, then comparison 2 ns later.
    always @(posedge clk_ser) begin
        cyc++;
        if (rst) begin
            m_cnt   = 0;
            m_q.delete();
            m_raw   = 1'b0;
            m_valid = 1'b0;
            m_wclk  = wlevel(0, int'(phase_sel));
        end else begin
            if (m_cnt == 15) begin
                // R4: the word is only sampled here
                m_q.delete();
                for (int b = 15; b >= 0; b--) m_q.push_back(word_in[b]);
                m_raw   = m_q.pop_front();
                m_valid = ((^word_in) == parity_in);
            end else if (m_q.size() > 0) begin
                m_raw = m_q.pop_front();
            end else begin
                m_raw = 1'b0;
            end
            m_cnt  = (m_cnt + 1) % 16;
            m_wclk = wlevel(m_cnt, int'(phase_sel));
        end
        #2;
        chk("R2/R4/R5/R9/R10 ser_out", ser_out, inv_n ? m_raw : ~m_raw);
        chk("R6 lpbk_out", lpbk_out, lpbk_en_n ? 1'b0 : m_raw);
        chk("R3/R9 valid_out", valid_out, m_valid);
        chk("R1/R8 wclk_out", wclk_out, m_wclk);
        chk("R7 sclk_out high phase", sclk_out, sclk_en);
    end

    always @(negedge clk_ser) begin
        #2;
        chk("R7 sclk_out low phase", sclk_out, 1'b0);
    end

    task automatic drive(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_ser);
            case (mode)
                0: begin word_in = 16'($urandom); parity_in = ^word_in; end
                1: begin word_in = 16'($urandom); parity_in = (^word_in) ^ 1'($urandom); end
                2: begin word_in = 16'hFFFF; parity_in = 1'b0; end
                3: begin word_in = 16'h0000; parity_in = 1'b1; end
                default: begin word_in = 16'h8001; parity_in = 1'b0; end
            endcase
        end
    endtask

    initial begin
        repeat (4) @(negedge clk_ser);
        rst = 1'b0;
        drive(80, 0);                      // R1 R2 R3 good parity
        drive(32, 2);                      // R3 all ones, even count
        drive(32, 3);                      // R3 zero word with wrong parity
        inv_n = 1'b0; lpbk_en_n = 1'b0;    // R5 R6
        for (int k = 0; k < 12; k++) begin
            drive(8, 1);
            inv_n = ~inv_n;
        end
        for (int p = 1; p < 4; p++) begin  // R8
            phase_sel = 2'(p);
            drive(48, 1);
        end
        sclk_en = 1'b0;                    // R7
        drive(32, 0);
        sclk_en = 1'b1;
        drive(7, 0);
        rst = 1'b1;                        // R9 mid-word reset
        drive(2, 1);
        rst = 1'b0;
        drive(40, 1);
        lpbk_en_n = 1'b1; inv_n = 1'b1; phase_sel = 2'd0;
        drive(48, 4);                      // R2 end bits
        @(negedge clk_ser);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_ser);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule